// File: doc/BRIEF.md
# Mutually Exclusive Delayable Task Pair

The block controls two tasks that may never run together. Each task has a small controller with three states: idle, waiting and running. A request in idle either starts the task at once or parks it in the waiting state. A waiting task starts as soon as the shared resource is free. An end pulse from a running task returns it to idle. An arbiter inside the block decides each cycle which controller may start. It never grants a task while the other task is running. When both tasks want to start, task 0 goes first.

The environment is expected never to raise both requests in the same cycle. If it does, neither task is granted in that cycle. A requesting idle task moves to waiting, so no request is lost. An error flag is set and stays set until reset. The start outputs are combinational and pulse in the cycle a grant is issued. The active outputs are registered and rise on the following edge. The task count is a parameter with a default of two.

Top module: `mutex_task_pair`

## Requirements
- R1: After reset (rst_ni low, asynchronous), both tasks are idle and active_o, start_o and err_o are all 0.
- R2: An idle task whose req_i bit is high, while the other task is not active and no other task is granted, gets its start_o bit high in that same cycle. Its active_o bit is 1 from the next cycle.
- R3: An idle task that requests while it cannot be granted keeps start_o low and enters waiting. A waiting task raises start_o in the first cycle it can be granted, regardless of req_i, and is active from the next cycle.
- R4: An active task has active_o high and start_o low. Its req_i is ignored. An end_i pulse makes its active_o 0 from the next cycle.
- R5: At most one bit of active_o is 1 in any cycle, and at most one bit of start_o is 1 in any cycle.
- R6: No grant is issued while any task is active, including the cycle in which that task ends. A waiting task therefore starts in the cycle after the other task's active_o falls.
- R7: When several tasks want to start in the same cycle, the lowest index (task 0) is granted and the others keep waiting.
- R8: In a cycle with both req_i bits high, start_o is 0, each requesting idle task enters waiting, and err_o is 1 from the next cycle until reset.
- R9: end_i has no effect on a task that is idle or waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_TASKS | Start request per task, bit 0 = task 0 |
| end_i | input | NUM_TASKS | Completion pulse per task |
| active_o | output | NUM_TASKS | Task is running (registered) |
| start_o | output | NUM_TASKS | Start command, high in the granting cycle |
| err_o | output | 1 | Sticky flag for simultaneous requests |

## Verification
The critical coincidence is a running task ending in the same cycle that the other, waiting task would be granted. The bench holds task 1 waiting behind an active task 0 and pulses end_i[0]. It expects no start in that cycle and a start exactly one cycle later. The second coincidence is two requests in the same cycle. Here the bench expects no start, both tasks parked in waiting, task 0 released first, and the error flag set on the next edge. A reference model compares all outputs on every cycle, including a long run of random requests that respect the single-request assumption.

// File: rtl/mtp_pkg.sv
package mtp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_ACTIVE = 2'd2
  } task_state_e;
endpackage

// File: rtl/mtp_task_fsm.sv
module mtp_task_fsm
  import mtp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic end_i,
  input  logic grant_i,
  output logic want_o,
  output logic active_o,
  output logic start_o
);
  task_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    start_o = 1'b0;
    want_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        want_o  = req_i;
        start_o = req_i & grant_i;
        if (req_i) state_d = grant_i ? ST_ACTIVE : ST_WAIT;
      end
      ST_WAIT: begin
        want_o  = 1'b1;
        start_o = grant_i;
        if (grant_i) state_d = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (end_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign active_o = (state_q == ST_ACTIVE);
endmodule

// File: rtl/mtp_arbiter.sv
module mtp_arbiter #(
  parameter int unsigned NUM_TASKS = 2
) (
  input  logic [NUM_TASKS-1:0] want_i,
  input  logic [NUM_TASKS-1:0] active_i,
  input  logic [NUM_TASKS-1:0] req_i,
  output logic [NUM_TASKS-1:0] grant_o,
  output logic                 clash_o
);
  logic busy;
  logic taken;

  assign busy    = |active_i;
  assign clash_o = ($countones(req_i) > 1);

  // fixed priority, lowest index first
  always_comb begin
    taken   = 1'b0;
    grant_o = '0;
    for (int i = 0; i < NUM_TASKS; i++) begin
      grant_o[i] = want_i[i] & ~busy & ~clash_o & ~taken;
      taken      = taken | grant_o[i];
    end
  end
endmodule

// File: rtl/mtp_err_latch.sv
module mtp_err_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  output logic err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_o <= 1'b0;
    else if (set_i) err_o <= 1'b1;
  end
endmodule

// File: rtl/mutex_task_pair.sv
module mutex_task_pair #(
  parameter int unsigned NUM_TASKS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_TASKS-1:0] req_i,
  input  logic [NUM_TASKS-1:0] end_i,
  output logic [NUM_TASKS-1:0] active_o,
  output logic [NUM_TASKS-1:0] start_o,
  output logic                 err_o
);
  logic [NUM_TASKS-1:0] want;
  logic [NUM_TASKS-1:0] grant;
  logic                 clash;

  for (genvar g = 0; g < NUM_TASKS; g++) begin : g_task
    mtp_task_fsm u_fsm (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (req_i[g]),
      .end_i   (end_i[g]),
      .grant_i (grant[g]),
      .want_o  (want[g]),
      .active_o(active_o[g]),
      .start_o (start_o[g])
    );
  end

  mtp_arbiter #(.NUM_TASKS(NUM_TASKS)) u_arb (
    .want_i  (want),
    .active_i(active_o),
    .req_i   (req_i),
    .grant_o (grant),
    .clash_o (clash)
  );

  mtp_err_latch u_err (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (clash),
    .err_o (err_o)
  );
endmodule

// File: rtl/mtp_checker.sv
module mtp_checker #(
  parameter int unsigned NUM_TASKS = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_TASKS-1:0] req_i,
  input logic [NUM_TASKS-1:0] end_i,
  input logic [NUM_TASKS-1:0] active_o,
  input logic [NUM_TASKS-1:0] start_o,
  input logic                 err_o
);
  AST_ONE_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(active_o) <= 1); // R5
  AST_ONE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(start_o)); // R5
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|active_o) |-> (start_o == '0)); // R6
  AST_CLASH_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(req_i) > 1) |-> (start_o == '0)); // R8
  AST_CLASH_SETS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(req_i) > 1) |=> err_o); // R8
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R8

  for (genvar g = 0; g < NUM_TASKS; g++) begin : g_chk
    AST_START_TO_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_o[g] |=> active_o[g]); // R2
    AST_ACTIVE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_o[g] && !end_i[g]) |=> active_o[g]); // R4
    AST_END_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_o[g] && end_i[g]) |=> !active_o[g]); // R4
    AST_RISE_NEEDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!active_o[g] && !start_o[g]) |=> !active_o[g]); // R3
  end
endmodule

bind mutex_task_pair mtp_checker #(.NUM_TASKS(NUM_TASKS)) u_mtp_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .end_i   (end_i),
  .active_o(active_o),
  .start_o (start_o),
  .err_o   (err_o)
);

// File: tb/mutex_task_pair_test.sv
`timescale 1ns/1ps
module mutex_task_pair_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] req_i = '0;
  logic [1:0] end_i = '0;
  logic [1:0] active_o;
  logic [1:0] start_o;
  logic       err_o;

  int n_tests = 0;
  int n_fail  = 0;

  // model: 0 idle, 1 waiting, 2 running
  int m_st[2];
  bit m_err;

  always #2.5 clk_i = ~clk_i;

  mutex_task_pair uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .end_i(end_i),
    .active_o(active_o), .start_o(start_o), .err_o(err_o)
  );

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {err,active,start} actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive inputs mid-low phase, compare, then let the edge update
  task automatic step(input string tag, input logic [1:0] rq, input logic [1:0] en);
    int winner;
    logic [1:0] e_start, e_act;
    bit running;
    @(negedge clk_i);
    req_i = rq;
    end_i = en;
    #1;
    running = (m_st[0] == 2) || (m_st[1] == 2);
    winner = -1;
    if (!running && rq != 2'b11) begin
      for (int k = 1; k >= 0; k--)
        if (m_st[k] == 1 || (m_st[k] == 0 && rq[k])) winner = k;
    end
    for (int k = 0; k < 2; k++) begin
      e_start[k] = (winner == k);
      e_act[k]   = (m_st[k] == 2);
    end
    check(tag, {err_o, active_o, start_o}, {m_err, e_act, e_start});
    @(posedge clk_i);
    if (rq == 2'b11) m_err = 1'b1;
    for (int k = 0; k < 2; k++) begin
      case (m_st[k])
        0: if (rq[k]) m_st[k] = (winner == k) ? 2 : 1;
        1: if (winner == k) m_st[k] = 2;
        default: if (en[k]) m_st[k] = 0;
      endcase
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    req_i = '0; end_i = '0;
    rst_ni = 1'b0;
    #1;
    m_st[0] = 0; m_st[1] = 0; m_err = 1'b0;
    check("R1 reset", {err_o, active_o, start_o}, 5'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    step("R1 idle", 2'b00, 2'b00);
    // R2 immediate start, R4 hold with req ignored, end
    step("R2 start", 2'b01, 2'b00);
    step("R4 running", 2'b01, 2'b00);
    step("R4 running", 2'b00, 2'b00);
    step("R4 end", 2'b00, 2'b01);
    step("R4 idle again", 2'b00, 2'b00);
    // R3 blocked request waits, R9 end ignored while waiting, R6 ending cycle
    step("R2 start t0", 2'b01, 2'b00);
    step("R3 t1 blocked", 2'b10, 2'b00);
    step("R9 end on waiting", 2'b00, 2'b10);
    step("R3 still waiting", 2'b00, 2'b00);
    step("R6 end cycle no grant", 2'b00, 2'b01);
    step("R6 start next cycle", 2'b00, 2'b00);
    step("R5 t1 running", 2'b00, 2'b00);
    step("R9 end on idle t0", 2'b00, 2'b01);
    step("R4 end t1", 2'b00, 2'b10);
    step("R4 idle", 2'b00, 2'b00);
    // R8 clash, R7 priority to task 0
    step("R8 clash", 2'b11, 2'b00);
    step("R7 t0 first", 2'b00, 2'b00);
    step("R8 err sticky", 2'b00, 2'b00);
    step("R7 t1 waits", 2'b00, 2'b01);
    step("R7 t1 after", 2'b00, 2'b00);
    step("R8 err held", 2'b00, 2'b10);
    do_reset();
    step("R1 err cleared", 2'b00, 2'b00);
    // R5 random traffic under the single-request assumption
    for (int c = 0; c < 3000; c++) begin
      int r;
      logic [1:0] rq;
      r = $urandom % 5;
      rq = (r == 0) ? 2'b01 : (r == 1) ? 2'b10 : 2'b00;
      step("R5 random", rq, 2'($urandom % 4) & {($urandom % 3 == 0), ($urandom % 3 == 0)});
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule